// File: doc/BRIEF.md
# Criticality-Ordered Pointer Ring Controller

This block keeps up to four circular rings of message-buffer pointers in a shared-memory, two-processor system. Each ring serves one criticality level. A sender pushes a pointer into a chosen ring, and a receiver pops pointers from a chosen ring in arrival order. The payloads stay in memory, so only references move between the two sides. For each ring the block keeps three indices: the next free slot, the next unread slot, and the oldest slot the sender has not yet reclaimed. The oldest-slot index moves only when the receiver acknowledges, by naming the read position it had reached.

The sender can also write an acknowledgement or explicit-free pointer into the next free slot. That entry is then read in order with ordinary messages. Every event of interest becomes a 4-bit notification code, made of a 2-bit ring number and a 2-bit type. The codes are offered on a valid/ready channel to a downstream notification queue. Message notifications are rate-limited: one is raised only when a ring goes from empty to one unread entry, or when its unread count reaches a threshold. If a piggybacked acknowledgement or free pointer sits unread for too long, a forced acknowledgement notification is raised.

Ring 0 is the lowest criticality level. When it is full, it can be set to drop its oldest entry. Every other ring, including the highest, refuses pushes when full.

Top module: `ptr_ring_ctrl`

## Requirements
- R1: After reset every ring is empty: `pop_ready` is 0, `notif_valid` is 0, `wr_dropped` is 0, and a message write to any ring is accepted (`wr_ready` is 1).
- R2: An accepted write stores `wr_ptr` at the ring's write index, which then advances by one modulo DEPTH. An accepted pop presents the pointer at the ring's read index on `pop_ptr`, and that index then advances modulo DEPTH. Each ring therefore returns its pointers in write order and wraps around.
- R3: `pop_ready` is 1 only when the ring chosen by `pop_ring` holds at least one unread entry. A pop request on an empty ring changes nothing.
- R4: A ring is full when its write index plus one (modulo DEPTH) equals its owner index, so one slot always stays unused. An acknowledgement (`ack_valid`, `ack_ring`, `ack_idx`) sets the owner index to `ack_idx`, which frees all slots before that index for reuse.
- R5: When LOW_OVERWRITE is 1, a message write to a full ring 0 is accepted. The write overwrites the oldest entry, and any owner or read index that sat on the overwritten slot moves forward by one. `wr_dropped` pulses during that write cycle.
- R6: Rings 1 to 3 never overwrite. A write to any of them while full sees `wr_ready` at 0 and has no effect.
- R7: `notif_code` is {ring[1:0], type[1:0]}, with type 2'b00 message, 2'b01 acknowledgement and 2'b10 explicit free. Type 2'b11 is never emitted.
- R8: An accepted message write (kind 2'b00) raises a message notification for its ring if the ring's unread count after that cycle is exactly 1 or equals THRESH.
- R9: A write with kind 2'b01 (acknowledgement) or 2'b10 (explicit free) fills the next free slot, is read back in order like a message, and raises a notification of its own type. It is refused when the ring is full, even on ring 0.
- R10: If a piggybacked entry is still unread PB_TIMEOUT cycles after it was written, the block raises one forced acknowledgement notification for that ring.
- R11: A write with kind 2'b11 is refused (`wr_ready` is 0) and changes no ring.
- R12: Pending notifications are offered highest ring first and, within a ring, lowest type code first. Events of the same ring and type merge into one notification while pending. An offered code stays stable until `notif_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ring | input | 2 | Ring selected for the write |
| wr_kind | input | 2 | 00 message, 01 acknowledgement, 10 explicit free, 11 reserved |
| wr_ptr | input | PTR_W | Pointer to store |
| wr_ready | output | 1 | Write would be accepted this cycle |
| wr_dropped | output | 1 | Accepted write overwrote the oldest entry |
| pop_valid | input | 1 | Pop request |
| pop_ring | input | 2 | Ring selected for the pop |
| pop_ready | output | 1 | Selected ring has an unread entry |
| pop_ptr | output | PTR_W | Pointer at the read index of the selected ring |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_ring | input | 2 | Ring being acknowledged |
| ack_idx | input | $clog2(DEPTH) | Read index reached by the receiver when it acknowledged |
| notif_valid | output | 1 | Notification code offered |
| notif_ready | input | 1 | Downstream queue accepts the code |
| notif_code | output | 4 | {ring, type} notification |

## Verification
The bench builds the block with four rings of depth 8, THRESH set to 3 and PB_TIMEOUT set to 6, with overwrite enabled on ring 0. With only seven usable slots per ring, short bursts reach the full condition, the wrap of every index and the overwrite path. The low threshold makes the rate-limited notification fire in the middle of a burst, apart from the empty-to-one case. The short timeout lets a forced acknowledgement show up within a few tens of cycles. A behavioural model is compared on every clock during directed scenarios and a long random phase. The random phase mixes pushes, pops, acknowledgements, piggybacked entries and back-pressure on the notification channel.

// File: rtl/ptr_ring_pkg.sv
package ptr_ring_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    K_MSG  = 2'b00,
    K_ACK  = 2'b01,
    K_FREE = 2'b10,
    K_RSV  = 2'b11
  } nkind_e;

  function automatic int unsigned ring_inc(input int unsigned i, input int unsigned d);
    return (i + 1 == d) ? 0 : i + 1;
  endfunction

  function automatic int unsigned ring_dist(input int unsigned a, input int unsigned b,
                                            input int unsigned d);
    return (a >= b) ? a - b : a + d - b;
  endfunction
endpackage

// File: rtl/ptr_ring_lane.sv
module ptr_ring_lane import ptr_ring_pkg::*; #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned PTR_W      = 16,
  parameter int unsigned THRESH     = 4,
  parameter int unsigned PB_TIMEOUT = 16,
  parameter bit          OVERWRITE  = 1'b0,
  localparam int unsigned IDX_W     = $clog2(DEPTH),
  localparam int unsigned AGE_W     = $clog2(PB_TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  nkind_e           wr_kind,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             rd_en,
  input  logic             ack_en,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             full,
  output logic             empty,
  output logic [PTR_W-1:0] head_ptr,
  output logic             drop,
  output logic             msg_evt,
  output logic             ack_evt,
  output logic             free_evt
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [PTR_W-1:0] slot_q [DEPTH];
  logic [IDX_W-1:0] end_q, rd_q, own_q, pb_pos_q;
  logic [IDX_W-1:0] end_n, rd_n, own_n, rd_a, own_a, cnt_n;
  logic [AGE_W-1:0] age_q;
  logic             pb_live_q, over_w, pb_w, pb_read_off, pb_fire;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return IDX_W'(ring_inc(32'(i), DEPTH));
  endfunction

  assign full     = (nxt(end_q) == own_q);
  assign empty    = (rd_q == end_q);
  assign head_ptr = slot_q[rd_q];

  always_comb begin
    rd_a   = rd_en  ? nxt(rd_q) : rd_q;
    own_a  = ack_en ? ack_idx   : own_q;
    over_w = wr_en && full && OVERWRITE;
    end_n  = wr_en ? nxt(end_q) : end_q;
    rd_n   = (over_w && rd_a  == end_n) ? nxt(rd_a)  : rd_a;
    own_n  = (over_w && own_a == end_n) ? nxt(own_a) : own_a;
    cnt_n  = IDX_W'(ring_dist(32'(end_n), 32'(rd_n), DEPTH));
  end

  assign drop        = over_w;
  assign pb_w        = wr_en && (wr_kind == K_ACK || wr_kind == K_FREE);
  assign pb_read_off = pb_live_q && (rd_q == pb_pos_q) && (rd_n != rd_q);
  assign pb_fire     = pb_live_q && !pb_read_off && (age_q == AGE_W'(PB_TIMEOUT - 1));
  assign msg_evt     = wr_en && wr_kind == K_MSG &&
                       (cnt_n == IDX_W'(1) || cnt_n == IDX_W'(THRESH));
  assign ack_evt     = (wr_en && wr_kind == K_ACK) || pb_fire;
  assign free_evt    = wr_en && wr_kind == K_FREE;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[end_q] <= wr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q     <= '0;
      rd_q      <= '0;
      own_q     <= '0;
      pb_live_q <= 1'b0;
      pb_pos_q  <= '0;
      age_q     <= '0;
    end else begin
      end_q <= end_n;
      rd_q  <= rd_n;
      own_q <= own_n;
      if (pb_w) begin
        pb_live_q <= 1'b1;
        pb_pos_q  <= end_q;
        age_q     <= '0;
      end else if (pb_read_off || pb_fire) begin
        pb_live_q <= 1'b0;
      end else if (pb_live_q) begin
        age_q <= age_q + AGE_W'(1);
      end
    end
  end

  // R6
  no_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full && !OVERWRITE));
  // R3
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && empty));
  // R5
  overwrite_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !ack_en) |=> full);
  // R10
  pb_age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_live_q |-> (age_q < AGE_W'(PB_TIMEOUT)));
endmodule

// File: rtl/notif_arb.sv
module notif_arb #(
  parameter int unsigned NUM_RINGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] msg_evt,
  input  logic [NUM_RINGS-1:0] ack_evt,
  input  logic [NUM_RINGS-1:0] free_evt,
  input  logic                 notif_ready,
  output logic                 notif_valid,
  output logic [3:0]           notif_code
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [NUM_RINGS-1:0][2:0] pend_q, set_v, clr_v;
  logic       hit, load;
  logic [3:0] pick;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    load = !notif_valid || notif_ready;
    for (int r = 0; r < int'(NUM_RINGS); r++) begin
      set_v[r] = {free_evt[r], ack_evt[r], msg_evt[r]};
      for (int t = 2; t >= 0; t--) begin
        if (pend_q[r][t]) begin
          hit  = 1'b1;
          pick = {2'(r), 2'(t)};
        end
      end
    end
    for (int r = 0; r < int'(NUM_RINGS); r++)
      for (int t = 0; t < 3; t++)
        clr_v[r][t] = load && hit && (pick == {2'(r), 2'(t)});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      notif_valid <= 1'b0;
      notif_code  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (load) begin
        notif_valid <= hit;
        notif_code  <= pick;
      end
    end
  end

  // R12
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notif_valid && !notif_ready) |=> (notif_valid && $stable(notif_code)));
  // R7
  no_reserved_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notif_valid |-> (notif_code[1:0] != 2'b11));
endmodule

// File: rtl/ptr_ring_ctrl.sv
module ptr_ring_ctrl import ptr_ring_pkg::*; #(
  parameter int unsigned NUM_RINGS     = 4,
  parameter int unsigned DEPTH         = 8,
  parameter int unsigned PTR_W         = 16,
  parameter int unsigned THRESH        = 4,
  parameter int unsigned PB_TIMEOUT    = 16,
  parameter bit          LOW_OVERWRITE = 1'b1,
  localparam int unsigned IDX_W        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [1:0]       wr_ring,
  input  logic [1:0]       wr_kind,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic             wr_ready,
  output logic             wr_dropped,
  input  logic             pop_valid,
  input  logic [1:0]       pop_ring,
  output logic             pop_ready,
  output logic [PTR_W-1:0] pop_ptr,
  input  logic             ack_valid,
  input  logic [1:0]       ack_ring,
  input  logic [IDX_W-1:0] ack_idx,
  output logic             notif_valid,
  input  logic             notif_ready,
  output logic [3:0]       notif_code
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [NUM_RINGS-1:0] full_v, empty_v, drop_v, msg_v, ack_v, free_v;
  logic [NUM_RINGS-1:0] wr_en_v, rd_en_v, ack_en_v;
  logic [PTR_W-1:0]     head_v [NUM_RINGS];
  logic                 sel_full, sel_ow;
  nkind_e               kind;

  assign kind = nkind_e'(wr_kind);

  always_comb begin
    sel_full  = 1'b1;
    sel_ow    = 1'b0;
    pop_ready = 1'b0;
    pop_ptr   = '0;
    for (int g = 0; g < int'(NUM_RINGS); g++) begin
      if (wr_ring == 2'(g)) begin
        sel_full = full_v[g];
        sel_ow   = (g == 0) && LOW_OVERWRITE;
      end
      if (pop_ring == 2'(g)) begin
        pop_ready = !empty_v[g];
        pop_ptr   = head_v[g];
      end
    end
    case (kind)
      K_MSG:         wr_ready = !sel_full || sel_ow;
      K_ACK, K_FREE: wr_ready = !sel_full;
      default:       wr_ready = 1'b0;
    endcase
  end

  assign wr_dropped = |drop_v;

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_lane
    assign wr_en_v[g]  = wr_valid && wr_ready && (wr_ring == 2'(g));
    assign rd_en_v[g]  = pop_valid && pop_ready && (pop_ring == 2'(g));
    assign ack_en_v[g] = ack_valid && (ack_ring == 2'(g));

    ptr_ring_lane #(
      .DEPTH(DEPTH), .PTR_W(PTR_W), .THRESH(THRESH), .PB_TIMEOUT(PB_TIMEOUT),
      .OVERWRITE((g == 0) && LOW_OVERWRITE)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_v[g]), .wr_kind(kind), .wr_ptr(wr_ptr),
      .rd_en(rd_en_v[g]), .ack_en(ack_en_v[g]), .ack_idx(ack_idx),
      .full(full_v[g]), .empty(empty_v[g]), .head_ptr(head_v[g]),
      .drop(drop_v[g]), .msg_evt(msg_v[g]), .ack_evt(ack_v[g]), .free_evt(free_v[g])
    );
  end

  notif_arb #(.NUM_RINGS(NUM_RINGS)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .msg_evt(msg_v), .ack_evt(ack_v), .free_evt(free_v),
    .notif_ready(notif_ready), .notif_valid(notif_valid), .notif_code(notif_code)
  );

  // R11
  reserved_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_kind == 2'b11) |-> !wr_ready);
  // R5
  drop_on_low_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |-> (wr_valid && wr_ring == 2'd0 && wr_kind == 2'b00));
endmodule

// File: tb/ptr_ring_ctrl_tb.sv
module ptr_ring_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int D = 8, NR = 4, TH = 3, TO = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, pop_valid = 0, ack_valid = 0, notif_ready = 1;
  logic [1:0] wr_ring = 0, wr_kind = 0, pop_ring = 0, ack_ring = 0;
  logic [15:0] wr_ptr = 0;
  logic [2:0] ack_idx = 0;
  logic wr_ready, wr_dropped, pop_ready, notif_valid;
  logic [15:0] pop_ptr;
  logic [3:0] notif_code;

  always #2 clk = ~clk;

  ptr_ring_ctrl #(.NUM_RINGS(NR), .DEPTH(D), .PTR_W(16), .THRESH(TH),
                  .PB_TIMEOUT(TO), .LOW_OVERWRITE(1'b1)) u_dut (.*);

  int checks = 0, fails = 0, drops_seen = 0, r2_ack_seen = 0;
  bit done = 0;

  int m_end[NR], m_rd[NR], m_own[NR], m_pbpos[NR], m_age[NR];
  bit m_pbl[NR];
  logic [15:0] m_mem[NR][D];
  bit m_pend[NR][3];
  bit m_ov;
  logic [3:0] m_oc;

  function automatic int inc(int i); return (i + 1) % D; endfunction
  function automatic bit m_full(int r); return inc(m_end[r]) == m_own[r]; endfunction

  function automatic bit m_wr_ready();
    int r = int'(wr_ring);
    case (wr_kind)
      2'b00: return !m_full(r) || r == 0;
      2'b01, 2'b10: return !m_full(r);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(bit awr, int wr_r, int kd, logic [15:0] wp, bit apop, int pr,
                              bit aack, int ar, int aidx, bit take);
    bit ev[NR][3];
    bit hit; int pr_r, pt;
    // arbitration from the old pending set
    hit = 0; pr_r = 0; pt = 0;
    for (int r = 0; r < NR; r++)
      for (int t = 2; t >= 0; t--)
        if (m_pend[r][t]) begin hit = 1; pr_r = r; pt = t; end
    for (int r = 0; r < NR; r++) begin
      int rd1, own1, endn, cnt; bit we, ovr, roff, fire;
      for (int t = 0; t < 3; t++) ev[r][t] = 0;
      we   = awr && wr_r == r;
      rd1  = (apop && pr == r) ? inc(m_rd[r]) : m_rd[r];
      own1 = (aack && ar == r) ? aidx : m_own[r];
      ovr  = we && m_full(r) && r == 0;
      endn = we ? inc(m_end[r]) : m_end[r];
      if (ovr && rd1 == endn) rd1 = inc(rd1);
      if (ovr && own1 == endn) own1 = inc(own1);
      if (we) m_mem[r][m_end[r]] = wp;
      cnt = (endn - rd1 + D) % D;
      roff = m_pbl[r] && m_rd[r] == m_pbpos[r] && rd1 != m_rd[r];
      fire = m_pbl[r] && !roff && m_age[r] == TO - 1;
      ev[r][0] = we && kd == 0 && (cnt == 1 || cnt == TH);
      ev[r][1] = (we && kd == 1) || fire;
      ev[r][2] = we && kd == 2;
      if (we && (kd == 1 || kd == 2)) begin
        m_pbl[r] = 1; m_pbpos[r] = m_end[r]; m_age[r] = 0;
      end else if (roff || fire) m_pbl[r] = 0;
      else if (m_pbl[r]) m_age[r]++;
      m_end[r] = endn; m_rd[r] = rd1; m_own[r] = own1;
    end
    if (!m_ov || take) begin
      m_ov = hit;
      m_oc = 4'(pr_r * 4 + pt);
      if (hit) m_pend[pr_r][pt] = 0;
    end
    for (int r = 0; r < NR; r++)
      for (int t = 0; t < 3; t++) if (ev[r][t]) m_pend[r][t] = 1;
  endtask

  task automatic step();
    bit pw, pp, pd, awr, apop, aack, take;
    int wr_r, kd, pr, ar, aidx; logic [15:0] wp;
    #1;
    pw = m_wr_ready();
    chk("R4/R6/R11 wr_ready", 32'(wr_ready), 32'(pw));
    pp = m_rd[pop_ring] != m_end[pop_ring];
    chk("R3 pop_ready", 32'(pop_ready), 32'(pp));
    if (pp) chk("R2/R9 pop_ptr", 32'(pop_ptr), 32'(m_mem[pop_ring][m_rd[pop_ring]]));
    pd = wr_valid && pw && wr_kind == 2'b00 && wr_ring == 2'd0 && m_full(0);
    chk("R5 wr_dropped", 32'(wr_dropped), 32'(pd));
    chk("R12 notif_valid", 32'(notif_valid), 32'(m_ov));
    if (m_ov) chk("R7/R8/R10/R12 notif_code", 32'(notif_code), 32'(m_oc));
    if (wr_dropped) drops_seen++;
    if (notif_valid && notif_ready && notif_code == 4'b1001) r2_ack_seen++;
    awr = wr_valid && pw; wr_r = int'(wr_ring); kd = int'(wr_kind); wp = wr_ptr;
    apop = pop_valid && pp; pr = int'(pop_ring);
    aack = ack_valid; ar = int'(ack_ring); aidx = int'(ack_idx);
    take = notif_ready;
    @(posedge clk);
    model_update(awr, wr_r, kd, wp, apop, pr, aack, ar, aidx, take);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_valid = 0; pop_valid = 0; ack_valid = 0;
  endtask

  task automatic put(int r, int k, int p);
    idle(); wr_valid = 1; wr_ring = 2'(r); wr_kind = 2'(k); wr_ptr = 16'(p); step();
  endtask

  task automatic take(int r);
    idle(); pop_valid = 1; pop_ring = 2'(r); step();
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_end[r] = 0; m_rd[r] = 0; m_own[r] = 0; m_pbl[r] = 0; m_pbpos[r] = 0; m_age[r] = 0;
      for (int t = 0; t < 3; t++) m_pend[r][t] = 0;
      for (int i = 0; i < D; i++) m_mem[r][i] = 0;
    end
    m_ov = 0; m_oc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 pop_ready after reset", 32'(pop_ready), 0);
    chk("R1 notif_valid after reset", 32'(notif_valid), 0);
    chk("R1 wr_dropped after reset", 32'(wr_dropped), 0);
    chk("R1 wr_ready after reset", 32'(wr_ready), 1);
    @(negedge clk);

    // R2 R8: burst on ring 1, then drain in order
    for (int i = 0; i < 5; i++) put(1, 0, 'h100 + i);
    for (int i = 0; i < 5; i++) begin
      idle(); pop_valid = 1; pop_ring = 2'd1; #0.5;
      chk("R2 ring order", 32'(pop_ptr), 32'('h100 + i));
      step();
    end

    // R11: reserved kind leaves ring 1 empty
    put(1, 3, 'hBAD);
    idle(); pop_ring = 2'd1; #0.5;
    chk("R11 reserved write ignored", 32'(pop_ready), 0);
    step();

    // R6 then R4 on ring 3
    for (int i = 0; i < D - 1; i++) put(3, 0, 'h300 + i);
    idle(); wr_valid = 1; wr_ring = 2'd3; wr_kind = 2'b00; wr_ptr = 16'h3FF; #0.5;
    chk("R6 full high ring refuses", 32'(wr_ready), 0);
    step();
    for (int i = 0; i < 3; i++) take(3);
    idle(); ack_valid = 1; ack_ring = 2'd3; ack_idx = 3'(m_rd[3]); step();
    idle(); wr_valid = 1; wr_ring = 2'd3; wr_kind = 2'b00; wr_ptr = 16'h3FE; #0.5;
    chk("R4 ack frees slots", 32'(wr_ready), 1);
    step();

    // R5 overwrite on ring 0
    for (int i = 0; i < D; i++) put(0, 0, 'h500 + i);
    chk("R5 one drop", 32'(drops_seen), 1);
    idle(); pop_ring = 2'd0; #0.5;
    chk("R5 oldest dropped", 32'(pop_ptr), 32'h501);
    step();

    // R10 forced acknowledgement, then R9 in-order read of the piggyback
    r2_ack_seen = 0;
    put(2, 1, 'h2AC);
    idle(); repeat (20) step();
    chk("R10 piggyback plus forced ack", 32'(r2_ack_seen), 2);
    idle(); pop_valid = 1; pop_ring = 2'd2; #0.5;
    chk("R9 piggyback readable", 32'(pop_ptr), 32'h2AC);
    step();

    // random mix with back-pressure
    for (int n = 0; n < 4000; n++) begin
      idle();
      wr_valid = ($urandom % 2) == 0;
      wr_ring = 2'($urandom); wr_ptr = 16'($urandom);
      wr_kind = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      pop_valid = ($urandom % 3) == 0; pop_ring = 2'($urandom);
      ack_valid = ($urandom % 6) == 0; ack_ring = 2'($urandom);
      ack_idx = 3'(m_rd[ack_ring]);
      notif_ready = ($urandom % 4) != 0;
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule